// File: doc/BRIEF.md
# Multicore interrupt routing unit

The unit gathers two groups of up to 64 interrupt sources each and steers them to a set of processor cores. The first group forms a shared summary word in which most bits follow their level inputs and a fixed subset of timer-type bits latch on a pulse. The second group forms a second shared summary word that follows its level inputs. Every core owns one enable word per group. Each core receives two interrupt lines, each raised when its summary word ANDed with that core's enable word is non-zero.

Software reaches the enable words through a small register bus. Besides the plain write, each word has a set alias and a clear alias. With these, several agents can change single bits without a read-modify-write sequence and without a lock. For each core and each group a highest-set-bit encoder names the active source that the dispatch routine should service first.

Top module: `irq_route_unit`

## Requirements
- R1: After reset all enable words and all latched timer bits are zero, and every interrupt line and encoder valid flag is low.
- R2: A write with op 0 replaces the addressed enable word with the write data. A later read returns that word.
- R3: A write with op 1 ORs the write data into the addressed enable word.
- R4: A write with op 2 clears exactly the enable bits that are 1 in the write data and leaves the other bits unchanged.
- R5: The bus address is {op[1:0], index}. Index core*2 selects that core's first-group enable word and index core*2+1 selects its second-group word. A write changes no other word.
- R6: irq0_o[c] equals |(summary0 & enable0[c]) and irq1_o[c] equals |(src1_i & enable1[c]), with no register on the path.
- R7: Timer-type summary bits (default mask bits 48 to 55) latch one cycle after their input is high. They stay set until a write with op 3 to an even index below 2*NUM_CORES carries a 1 in that bit position.
- R8: Writing 1s with op 3 to non-timer bits or to an odd index has no effect. Non-timer bits of summary0 follow src0_i directly, and summary1 follows src1_i.
- R9: If a timer input is high in the same cycle that its bit is cleared, the bit remains set.
- R10: For each core and group, the encoder outputs the highest bit position set in summary AND enable, with a valid flag that is high exactly when that AND is non-zero.
- R11: An index of 2*NUM_CORES or above decodes to nothing. Writes to it are ignored and reads of it return zero.
- R12: Read data appears on bus_rdata_o in the cycle after the read request and is zero in any cycle that follows no read. Ops 0 to 2 read the enable word. Op 3 reads summary0 at an even index and summary1 at an odd index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src0_i | input | 64 | First-group sources (levels; pulses on timer bits) |
| src1_i | input | 64 | Second-group level sources |
| bus_vld_i | input | 1 | Bus request valid |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | {op, index} |
| bus_wdata_i | input | 64 | Write data or mask |
| bus_rdata_o | output | 64 | Read data, one cycle after the request |
| irq0_o | output | 4 | First-group interrupt line per core |
| irq1_o | output | 4 | Second-group interrupt line per core |
| sel0_o | output | 24 | Per-core highest active first-group bit (6 bits per core) |
| sel0_vld_o | output | 4 | Per-core valid flag for sel0_o |
| sel1_o | output | 24 | Per-core highest active second-group bit (6 bits per core) |
| sel1_vld_o | output | 4 | Per-core valid flag for sel1_o |

## Verification
The bench targets four bit-exact hazards:
- Clear aliases that touch neighbouring bits. A design with this fault would drop an enable set by another agent.
- Odd and even indices that are swapped. A design with this fault would route a group to the wrong line.
- A pulse that arrives on a timer bit in the same cycle as its clear. A design in which the clear wins would lose an event silently.
- Writes to level bits, to the second summary or to unmapped indices. A design that accepted them would corrupt state.

It also drives several source patterns so that encoder priority shows up when more than one bit is active.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  typedef enum logic [1:0] {
    OP_FULL = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_SUM  = 2'd3
  } reg_op_e;
endpackage

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_full_i,
  input  logic         wr_set_i,
  input  logic         wr_clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_o <= '0;
    else if (wr_full_i) en_o <= wdata_i;
    else if (wr_set_i)  en_o <= en_o | wdata_i;
    else if (wr_clr_i)  en_o <= en_o & ~wdata_i;
  end

  assert_full_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_full_i |=> en_o == $past(wdata_i));
  assert_set_alias_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set_i |=> ((en_o & $past(wdata_i)) == $past(wdata_i))
              && ((en_o & ~$past(wdata_i)) == ($past(en_o) & ~$past(wdata_i))));
  assert_clr_alias_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr_i |=> ((en_o & $past(wdata_i)) == '0)
              && ((en_o & ~$past(wdata_i)) == ($past(en_o) & ~$past(wdata_i))));
  assert_untouched_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_full_i || wr_set_i || wr_clr_i) |=> $stable(en_o));
endmodule

// File: rtl/irq_sum_latch.sv
module irq_sum_latch #(
  parameter int          W          = 64,
  parameter logic [63:0] TIMER_MASK = 64'h00FF_0000_0000_0000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         clr_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] sum_o
);
  localparam logic [W-1:0] TM = TIMER_MASK[W-1:0];

  logic [W-1:0] tmr_q;
  logic [W-1:0] kill;

  assign kill = clr_i ? clr_mask_i : '0;

  // set beats clear: the OR is applied after the mask
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmr_q <= '0;
    else         tmr_q <= ((tmr_q & ~kill) | src_i) & TM;
  end

  assign sum_o = (src_i & ~TM) | tmr_q;

  assert_pulse_latches_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_i & TM) != '0) |=> ((sum_o & $past(src_i & TM)) == $past(src_i & TM)));
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((tmr_q & $past(tmr_q)) == $past(tmr_q)));
  assert_only_timer_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_q & ~TM) == '0);
endmodule

// File: rtl/irq_msb_enc.sv
module irq_msb_enc #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          vld_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign vld_o = |vec_i;
endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit #(
  parameter int          NUM_CORES  = 4,
  parameter int          W          = 64,
  parameter logic [63:0] TIMER_MASK = 64'h00FF_0000_0000_0000,
  parameter int          SL_W       = $clog2(2*NUM_CORES),
  parameter int          IDX_W      = SL_W + 1,
  parameter int          AW         = IDX_W + 2,
  parameter int          IW         = $clog2(W)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [W-1:0]                  src0_i,
  input  logic [W-1:0]                  src1_i,
  input  logic                          bus_vld_i,
  input  logic                          bus_wr_i,
  input  logic [AW-1:0]                 bus_addr_i,
  input  logic [W-1:0]                  bus_wdata_i,
  output logic [W-1:0]                  bus_rdata_o,
  output logic [NUM_CORES-1:0]          irq0_o,
  output logic [NUM_CORES-1:0]          irq1_o,
  output logic [NUM_CORES-1:0][IW-1:0]  sel0_o,
  output logic [NUM_CORES-1:0]          sel0_vld_o,
  output logic [NUM_CORES-1:0][IW-1:0]  sel1_o,
  output logic [NUM_CORES-1:0]          sel1_vld_o
);
  import irq_route_pkg::*;

  localparam int NSLOT = 2 * NUM_CORES;

  reg_op_e                       op;
  logic [IDX_W-1:0]              idx;
  logic                          mapped;
  logic                          wr;
  logic                          sum_clr;
  logic [W-1:0]                  sum0;
  logic [W-1:0]                  sum1;
  logic [NSLOT-1:0][W-1:0]       en_w;
  logic [NUM_CORES-1:0][W-1:0]   act0;
  logic [NUM_CORES-1:0][W-1:0]   act1;

  assign op      = reg_op_e'(bus_addr_i[AW-1:IDX_W]);
  assign idx     = bus_addr_i[IDX_W-1:0];
  assign mapped  = int'(idx) < NSLOT;
  assign wr      = bus_vld_i && bus_wr_i && mapped;
  assign sum_clr = wr && (op == OP_SUM) && !idx[0];
  assign sum1    = src1_i;

  irq_sum_latch #(.W(W), .TIMER_MASK(TIMER_MASK)) u_sum0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src0_i),
    .clr_i      (sum_clr),
    .clr_mask_i (bus_wdata_i),
    .sum_o      (sum0)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic hit;
    assign hit = wr && (int'(idx) == s);
    irq_enable_bank #(.W(W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_full_i (hit && (op == OP_FULL)),
      .wr_set_i  (hit && (op == OP_SET)),
      .wr_clr_i  (hit && (op == OP_CLR)),
      .wdata_i   (bus_wdata_i),
      .en_o      (en_w[s])
    );
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign act0[c]   = sum0 & en_w[2*c];
    assign act1[c]   = sum1 & en_w[2*c+1];
    assign irq0_o[c] = |act0[c];
    assign irq1_o[c] = |act1[c];

    irq_msb_enc #(.W(W), .IW(IW)) u_enc0 (
      .vec_i (act0[c]),
      .idx_o (sel0_o[c]),
      .vld_o (sel0_vld_o[c])
    );
    irq_msb_enc #(.W(W), .IW(IW)) u_enc1 (
      .vec_i (act1[c]),
      .idx_o (sel1_o[c]),
      .vld_o (sel1_vld_o[c])
    );

    assert_line_vs_enc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq0_o[c] == sel0_vld_o[c] && irq1_o[c] == sel1_vld_o[c]);
    assert_msb_pick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel0_vld_o[c] |-> ((act0[c] >> sel0_o[c]) == W'(1)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata_o <= '0;
    end else if (bus_vld_i && !bus_wr_i && mapped) begin
      if (op == OP_SUM) bus_rdata_o <= idx[0] ? sum1 : sum0;
      else              bus_rdata_o <= en_w[idx[SL_W-1:0]];
    end else begin
      bus_rdata_o <= '0;
    end
  end

  assert_unmapped_wr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_vld_i && bus_wr_i && !mapped) |=> $stable(en_w));
  assert_unmapped_rd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_vld_i && !bus_wr_i && !mapped) |=> bus_rdata_o == '0);
  assert_idle_rdata_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_vld_i |=> bus_rdata_o == '0);
endmodule

// File: tb/irq_route_unit_test.sv
module irq_route_unit_test;
  localparam int          NC = 4;
  localparam logic [63:0] TM = 64'h00FF_0000_0000_0000;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [63:0]          src0 = '0, src1 = '0;
  logic                 vld = 1'b0, wr = 1'b0;
  logic [5:0]           addr = '0;
  logic [63:0]          wdata = '0;
  logic [63:0]          rdata;
  logic [NC-1:0]        irq0, irq1, s0v, s1v;
  logic [NC-1:0][5:0]   s0, s1;

  int checks = 0, fails = 0;
  logic [63:0] ref_en [8];
  logic [63:0] ref_tmr = '0;
  string tag = "R12";

  always #4 clk = ~clk;

  irq_route_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .src0_i(src0), .src1_i(src1),
    .bus_vld_i(vld), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq0_o(irq0), .irq1_o(irq1),
    .sel0_o(s0), .sel0_vld_o(s0v), .sel1_o(s1), .sel1_vld_o(s1v)
  );

  function automatic logic [63:0] m_sum0();
    return (src0 & ~TM) | ref_tmr;
  endfunction

  function automatic int top_bit(logic [63:0] v);
    int r = -1;
    for (int i = 0; i < 64; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic chk(string t, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic compare_lines();
    for (int c = 0; c < NC; c++) begin
      logic [63:0] a0 = m_sum0() & ref_en[2*c];
      logic [63:0] a1 = src1 & ref_en[2*c+1];
      chk("R6 irq0", 64'(irq0[c]), 64'(a0 != 0));
      chk("R6 irq1", 64'(irq1[c]), 64'(a1 != 0));
      chk("R10 vld0", 64'(s0v[c]), 64'(a0 != 0));
      chk("R10 vld1", 64'(s1v[c]), 64'(a1 != 0));
      if (a0 != 0) chk("R10 sel0", 64'(s0[c]), 64'(top_bit(a0)));
      if (a1 != 0) chk("R10 sel1", 64'(s1[c]), 64'(top_bit(a1)));
    end
  endtask

  // one clock: reference update at the edge, comparison at the falling edge
  task automatic step();
    logic [63:0] exp_rd = '0;
    logic [63:0] clr = '0;
    int ix;
    @(posedge clk);
    ix = int'(addr[3:0]);
    if (vld && !wr && ix < 8)
      exp_rd = (addr[5:4] == 2'd3) ? (ix % 2 == 1 ? src1 : m_sum0()) : ref_en[ix];
    if (vld && wr && ix < 8) begin
      case (addr[5:4])
        2'd0: ref_en[ix] = wdata;
        2'd1: ref_en[ix] = ref_en[ix] | wdata;
        2'd2: ref_en[ix] = ref_en[ix] & ~wdata;
        default: if (ix % 2 == 0) clr = wdata;
      endcase
    end
    ref_tmr = ((ref_tmr & ~clr) | src0) & TM;
    @(negedge clk);
    chk((vld && !wr) ? tag : "R12 idle", rdata, exp_rd);
    compare_lines();
  endtask

  task automatic bus_wr(logic [1:0] op, int ix, logic [63:0] d);
    vld = 1'b1; wr = 1'b1; addr = {op, 4'(ix)}; wdata = d;
    step();
    vld = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(logic [1:0] op, int ix, string t);
    vld = 1'b1; wr = 1'b0; addr = {op, 4'(ix)}; tag = t;
    step();
    vld = 1'b0; tag = "R12";
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) ref_en[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 irq0 in reset", 64'(irq0), 0);
    chk("R1 rdata in reset", rdata, 0);
    rst_ni = 1'b1;
    step();
    for (int i = 0; i < 8; i++) bus_rd(2'd0, i, "R1 enable zero");

    // R2 plain write and read-back
    bus_wr(2'd0, 0, 64'hDEAD_BEEF_0123_4567);
    bus_rd(2'd0, 0, "R2 full write");
    bus_wr(2'd0, 0, 64'h0000_0000_0000_00F0);
    bus_rd(2'd0, 0, "R2 replace");

    // R3 set alias
    bus_wr(2'd1, 2, 64'h0000_0000_0000_0005);
    bus_wr(2'd1, 2, 64'h8000_0000_0000_0004);
    bus_rd(2'd1, 2, "R3 set alias");

    // R4 clear alias
    bus_wr(2'd0, 3, 64'hFFFF_0000_FFFF_0000);
    bus_wr(2'd2, 3, 64'h0F0F_0000_0000_FFFF);
    bus_rd(2'd2, 3, "R4 clear alias");

    // R5 interleaved index
    bus_wr(2'd0, 5, 64'h0000_0000_0000_0300);
    bus_rd(2'd0, 4, "R5 even slot untouched");
    bus_rd(2'd0, 5, "R5 odd slot");
    bus_rd(2'd0, 2, "R5 other core untouched");

    // R6 / R10 source patterns
    src0 = 64'h0000_0000_0000_0030; step();
    src0 = 64'h8000_0000_0000_0001; step();
    src1 = 64'h0000_0000_0000_0200; step();
    src1 = 64'h0000_0000_0001_0100; step();
    bus_wr(2'd0, 6, 64'hFFFF_FFFF_FFFF_FFFF);
    src0 = 64'h0000_0001_0000_0010; step();
    src0 = '0; src1 = '0; step();

    // R7 sticky timer bit, cleared through another core's index
    bus_wr(2'd1, 0, 64'h0004_0000_0000_0000);
    src0 = 64'h0004_0000_0000_0000; step();
    src0 = '0; step(); step();
    bus_rd(2'd3, 0, "R7 latched");
    bus_wr(2'd3, 2, 64'h0004_0000_0000_0000);
    bus_rd(2'd3, 6, "R7 cleared");

    // R8 writes to level bits and the second summary
    src0 = 64'h0000_0000_0000_00F0; src1 = 64'h0000_0000_0000_0003;
    bus_wr(2'd3, 0, 64'h0000_0000_0000_00F0);
    bus_wr(2'd3, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_rd(2'd3, 0, "R8 level bits follow input");
    bus_rd(2'd3, 1, "R8 summary1 follows input");
    src0 = '0; src1 = '0; step();

    // R9 pulse and clear in the same cycle
    src0 = 64'h0010_0000_0000_0000; step();
    src0 = '0;
    src0 = 64'h0010_0000_0000_0000;
    bus_wr(2'd3, 0, 64'h0010_0000_0000_0000);
    src0 = '0;
    bus_rd(2'd3, 0, "R9 set wins");
    bus_wr(2'd3, 0, 64'h0010_0000_0000_0000);
    bus_rd(2'd3, 0, "R9 clear alone");

    // R11 unmapped indices
    bus_wr(2'd0, 8, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_wr(2'd1, 15, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_rd(2'd0, 8, "R11 read zero");
    bus_rd(2'd3, 9, "R11 summary read zero");
    for (int i = 0; i < 8; i++) bus_rd(2'd0, i, "R11 slots intact");

    // R12 back-to-back reads then idle
    bus_rd(2'd0, 0, "R12 read A");
    bus_rd(2'd0, 3, "R12 read B");
    step(); step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule